// File: doc/BRIEF.md
# Wiper Register File Target on a Two-Wire Serial Bus

This block is a two-wire serial bus target that lets a host reach a small register file. The file has nine byte locations. Locations 00h to 03h are four 7-bit wiper positions, locations 04h to 07h are four 7-bit start-up values, and location 08h is an 8-bit control byte. The wiper positions and the control byte also leave the block as parallel outputs, so they can steer the analog side directly.

The clock and data lines arrive already synchronized to the system clock. The block finds bus conditions and bit edges itself, and it drives the data line through an open-drain enable. A host first sends an identification byte and then an address byte that sets an internal pointer. After that it either writes bytes, or it issues a repeated start and reads bytes back. In both directions the pointer steps through the nine locations and wraps around.

Top module: `i2c_wiper_target`

## Requirements
- R1: The first byte after a start is acknowledged only if its upper seven bits equal binary 1010 followed by the latched strap pins (pin 2 first). On a mismatch the block does not acknowledge that byte or any later byte, and it leaves all registers unchanged until the next start or stop.
- R2: The strap pins are latched only while the bus is idle. A change on the pins after a start has no effect on address matching, repeated starts included, until a stop has been seen.
- R3: With bit 0 of the identification byte at 0, the next byte loads the pointer and is acknowledged if its value is 00h to 08h. A larger value is not acknowledged, and the rest of that transaction is ignored.
- R4: Each later data byte is acknowledged, stored at the pointer location, and advances the pointer by one. The pointer goes from 08h back to 00h.
- R5: Locations 00h to 07h keep only the low 7 bits of a written byte and read back with bit 7 at 0. Location 08h keeps all 8 bits. The wiper output carries location n in bits [7n+6:7n].
- R6: After a repeated start and an identification byte with bit 0 at 1, the block returns bytes MSB first, starting at the pointer. The pointer advances by one per byte, with the same wrap from 08h to 00h.
- R7: When the host does not acknowledge a read byte, the block releases the data line and drives nothing more until the next start. A stop returns the block to idle with the data line released.
- R8: A start or stop that arrives partway through a byte abandons that byte without writing any register. A new transaction then works normally.
- R9: The data-line enable changes only while the clock line is low. Bits are taken on the clock rising edge.
- R10: After reset the data line is released, every wiper and start-up location holds 40h, and the control byte is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line, as seen on the wire |
| addr_pins | input | 3 | Strap pins that form the low address bits |
| sda_oe | output | 1 | When 1, the data line is pulled low |
| wiper_pos | output | 28 | Four 7-bit wiper positions, location 0 in the low bits |
| ctrl_reg | output | 8 | Control byte at location 08h |

## Verification
Two things can happen in the same clock cycle: the write strobe for location 08h and the pointer wrap back to 00h. The bench causes this with a burst write that starts at 07h and runs past 08h, and then with a read burst over the same span. A pass requires location 08h to hold its byte, the next byte to land in 00h, and the read to return the three bytes in that same order. Mid-byte aborts and address mismatches are judged on the outputs: the registers they could have changed must keep their old values.

// File: rtl/i2c_wiper_pkg.sv
package i2c_wiper_pkg;
  localparam int NUM_WIPERS = 4;
  localparam int WIPER_W    = 7;
  localparam int DATA_W     = 8;
  localparam int PIN_W      = 3;
  localparam int NUM_REGS   = 2 * NUM_WIPERS + 1;
  localparam int CTRL_IDX   = NUM_REGS - 1;
  localparam int PTR_W      = $clog2(NUM_REGS);
  localparam int BIT_W      = $clog2(DATA_W);
  localparam logic [DATA_W-PIN_W-2:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } bus_state_e;
endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_d;
  logic sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
    end
  end

  // Bus conditions need the clock line high in both samples
  always_comb begin
    scl_rise  = scl_i & ~scl_d;
    scl_fall  = ~scl_i & scl_d;
    start_det = scl_i & scl_d & sda_d & ~sda_i;
    stop_det  = scl_i & scl_d & ~sda_d & sda_i;
  end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_wiper_pkg::*;
#(
  parameter logic [WIPER_W-1:0] WIPER_INIT = 7'h40
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [PTR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [PTR_W-1:0]              rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  output logic [NUM_WIPERS*WIPER_W-1:0] wiper_pos,
  output logic [DATA_W-1:0]             ctrl_reg
);
  localparam logic [PTR_W-1:0]  CTRL_PTR    = PTR_W'(CTRL_IDX);
  localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'((1 << WIPER_W) - 1);
  localparam logic [DATA_W-1:0] INIT_BYTE   = DATA_W'(WIPER_INIT);

  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        mem[i] <= (i == CTRL_IDX) ? '0 : INIT_BYTE;
      end
    end else if (wr_en) begin
      mem[wr_addr] <= (wr_addr == CTRL_PTR) ? wr_data : (wr_data & NARROW_MASK);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= mem[rd_addr];
  end

  for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_wiper_out
    assign wiper_pos[g*WIPER_W +: WIPER_W] = mem[g][WIPER_W-1:0];
  end
  assign ctrl_reg = mem[CTRL_IDX];

  // R5: a narrow location never reads back with its top bit set
  p_narrow_msb_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) != CTRL_PTR) |-> !rd_data[DATA_W-1]);
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_wiper_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_i,
  input  logic              scl_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [PIN_W-1:0]  addr_pins,
  input  logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  ptr,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam logic [BIT_W:0]    ACK_SLOT  = (BIT_W+1)'(DATA_W);
  localparam logic [BIT_W:0]    LAST_BIT  = (BIT_W+1)'(DATA_W - 1);
  localparam logic [PTR_W-1:0]  LAST_PTR  = PTR_W'(CTRL_IDX);
  localparam logic [DATA_W-1:0] LAST_ADDR = DATA_W'(CTRL_IDX);

  bus_state_e        state;
  logic [BIT_W:0]    bitcnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] byte_now;
  logic [PIN_W-1:0]  pins_q;
  logic              rw_q;
  logic [PTR_W-1:0]  ptr_next;
  logic [BIT_W-1:0]  tx_idx;

  always_comb begin
    byte_now = {shreg[DATA_W-2:0], sda_i};
    ptr_next = (ptr == LAST_PTR) ? '0 : ptr + 1'b1;
    tx_idx   = BIT_W'(DATA_W - 1) - bitcnt[BIT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      pins_q  <= '0;
      rw_q    <= 1'b0;
      ptr     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      sda_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (state == ST_IDLE) pins_q <= addr_pins;

      if (start_det) begin
        state  <= ST_ID;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        if (bitcnt != ACK_SLOT) begin
          shreg  <= byte_now;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == LAST_BIT) begin
            case (state)
              ST_ID: begin
                if (byte_now[DATA_W-1:1] == {DEV_PREFIX, pins_q}) rw_q <= byte_now[0];
                else                                              state <= ST_IGNORE;
              end
              ST_ADDR: begin
                if (byte_now <= LAST_ADDR) ptr   <= byte_now[PTR_W-1:0];
                else                       state <= ST_IGNORE;
              end
              ST_WDATA: begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= byte_now;
                ptr     <= ptr_next;
              end
              ST_RDATA: ptr <= ptr_next;
              default: ;
            endcase
          end
        end else begin
          bitcnt <= '0;
          case (state)
            ST_ID:    state <= rw_q ? ST_RDATA : ST_ADDR;
            ST_ADDR:  state <= ST_WDATA;
            ST_RDATA: if (sda_i) state <= ST_IGNORE;
            default: ;
          endcase
        end
      end else if (scl_fall) begin
        case (state)
          ST_ID, ST_ADDR, ST_WDATA: sda_oe <= (bitcnt == ACK_SLOT);
          ST_RDATA:                 sda_oe <= (bitcnt != ACK_SLOT) && !rd_data[tx_idx];
          default:                  sda_oe <= 1'b0;
        endcase
      end
    end
  end

  // R9: the data line enable only moves after a low clock sample
  p_sda_low_only_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_i));
  // R8: a start always rearms byte reception from the first bit
  p_start_rearms_r8: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ID && bitcnt == '0));
  // R7: a stop leaves the target idle with the line released
  p_stop_idle_r7: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !sda_oe));
  // R4: the pointer never leaves the register range
  p_ptr_range_r4: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST_PTR);
  // R4: one strobe per received data byte
  p_wr_single_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
endmodule

// File: rtl/i2c_wiper_target.sv
module i2c_wiper_target
  import i2c_wiper_pkg::*;
#(
  parameter logic [WIPER_W-1:0] WIPER_INIT = 7'h40
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          scl_i,
  input  logic                          sda_i,
  input  logic [PIN_W-1:0]              addr_pins,
  output logic                          sda_oe,
  output logic [NUM_WIPERS*WIPER_W-1:0] wiper_pos,
  output logic [DATA_W-1:0]             ctrl_reg
);
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [PTR_W-1:0]  ptr;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  i2c_bus_events u_events (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sda_i     (sda_i),
    .scl_i     (scl_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .addr_pins (addr_pins),
    .rd_data   (rd_data),
    .ptr       (ptr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe)
  );

  i2c_reg_bank #(.WIPER_INIT(WIPER_INIT)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (ptr),
    .rd_data   (rd_data),
    .wiper_pos (wiper_pos),
    .ctrl_reg  (ctrl_reg)
  );
endmodule

// File: tb/sim_i2c_wiper_target.sv
module sim_i2c_wiper_target;
  localparam int Q = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_scl = 1'b1;
  logic        h_sda = 1'b1;
  logic [2:0]  pins = 3'b010;
  logic        sda_oe;
  logic [27:0] wiper_pos;
  logic [7:0]  ctrl_reg;
  logic        bus_sda;

  int n_checks = 0;
  int n_fail = 0;
  int r9_viol = 0;
  bit done = 1'b0;

  assign bus_sda = h_sda & ~sda_oe;

  always #10 clk = ~clk;

  i2c_wiper_target u0 (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (h_scl),
    .sda_i     (bus_sda),
    .addr_pins (pins),
    .sda_oe    (sda_oe),
    .wiper_pos (wiper_pos),
    .ctrl_reg  (ctrl_reg)
  );

  // R9 monitor: the enable must not move while the clock line stays high
  logic prev_scl = 1'b1;
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (!rst && h_scl && prev_scl && (sda_oe != prev_oe)) r9_viol++;
    prev_scl <= h_scl;
    prev_oe  <= sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] wp(input int n);
    return wiper_pos[n*7 +: 7];
  endfunction

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    h_sda = 1'b1; hold(); h_scl = 1'b1; hold();
    h_sda = 1'b0; hold(); h_scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    h_sda = 1'b0; hold(); h_scl = 1'b1; hold(); h_sda = 1'b1; hold();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      h_sda = b[i]; hold(); h_scl = 1'b1; hold(); h_scl = 1'b0;
    end
    hold();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    h_sda = 1'b1; h_scl = 1'b1; hold();
    ack = !bus_sda;
    h_scl = 1'b0; hold();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    h_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(); h_scl = 1'b1; hold(); b[i] = bus_sda; h_scl = 1'b0;
    end
    h_sda = give_ack ? 1'b0 : 1'b1;
    hold(); h_scl = 1'b1; hold(); h_scl = 1'b0; hold();
    h_sda = 1'b1;
  endtask

  function automatic logic [7:0] id_byte(input logic [2:0] p, input bit rd);
    return {4'b1010, p, rd};
  endfunction

  task automatic write_burst(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1,
                             input logic [7:0] d2, input int n, input string tag);
    bit ack;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start();
    send_byte(id_byte(3'b010, 1'b0), ack); chk(ack, {tag, " id ack"}, ack, 1);
    send_byte(a, ack);                     chk(ack, {tag, " addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack); chk(ack, {tag, " data ack"}, ack, 1);
    end
    bus_stop();
  endtask

  task automatic t_reset();
    hold();
    chk(sda_oe == 1'b0, "R10 sda released", sda_oe, 0);
    chk(wiper_pos == {4{7'h40}}, "R10 wiper init", wiper_pos, {4{7'h40}});
    chk(ctrl_reg == 8'h00, "R10 ctrl init", ctrl_reg, 0);
  endtask

  task automatic t_write_basic();
    write_burst(8'h00, 8'h12, 8'h34, 8'h00, 2, "R4");
    chk(wp(0) == 7'h12, "R4 wiper0", wp(0), 'h12);
    chk(wp(1) == 7'h34, "R4 wiper1", wp(1), 'h34);
  endtask

  task automatic t_msb_mask();
    bit ack;
    logic [7:0] b;
    write_burst(8'h02, 8'h85, 8'h00, 8'h00, 1, "R5");
    chk(wp(2) == 7'h05, "R5 wiper2 masked", wp(2), 'h05);
    write_burst(8'h08, 8'hA5, 8'h00, 8'h00, 1, "R5");
    chk(ctrl_reg == 8'hA5, "R5 ctrl full byte", ctrl_reg, 'hA5);
    bus_start();
    send_byte(id_byte(3'b010, 1'b0), ack);
    send_byte(8'h02, ack);
    bus_start();
    send_byte(id_byte(3'b010, 1'b1), ack); chk(ack, "R6 read id ack", ack, 1);
    recv_byte(1'b0, b);
    chk(b == 8'h05, "R5 readback msb zero", b, 'h05);
    bus_stop();
  endtask

  task automatic t_wrap();
    bit ack;
    logic [7:0] b;
    // strobe for 08h and pointer wrap fall in the same cycle
    write_burst(8'h07, 8'h11, 8'h9C, 8'h22, 3, "R4");
    chk(ctrl_reg == 8'h9C, "R4 08h written", ctrl_reg, 'h9C);
    chk(wp(0) == 7'h22, "R4 wrap to 00h", wp(0), 'h22);
    bus_start();
    send_byte(id_byte(3'b010, 1'b0), ack);
    send_byte(8'h07, ack);
    bus_start();
    send_byte(id_byte(3'b010, 1'b1), ack);
    recv_byte(1'b1, b); chk(b == 8'h11, "R6 read 07h", b, 'h11);
    recv_byte(1'b1, b); chk(b == 8'h9C, "R6 read 08h", b, 'h9C);
    recv_byte(1'b0, b); chk(b == 8'h22, "R6 read wrap 00h", b, 'h22);
    // R7: after the NACK the target must not drive any more bits
    recv_byte(1'b0, b); chk(b == 8'hFF, "R7 released after nack", b, 'hFF);
    bus_stop();
    chk(sda_oe == 1'b0, "R7 idle after stop", sda_oe, 0);
  endtask

  task automatic t_bad_id();
    bit ack;
    bus_start();
    send_byte(id_byte(3'b011, 1'b0), ack); chk(!ack, "R1 mismatch nack", ack, 0);
    send_byte(8'h00, ack);                 chk(!ack, "R1 later byte nack", ack, 0);
    send_byte(8'h77, ack);                 chk(!ack, "R1 data nack", ack, 0);
    bus_stop();
    chk(wp(0) == 7'h22, "R1 no write on mismatch", wp(0), 'h22);
  endtask

  task automatic t_bad_addr();
    bit ack;
    bus_start();
    send_byte(id_byte(3'b010, 1'b0), ack); chk(ack, "R3 id ack", ack, 1);
    send_byte(8'h09, ack);                 chk(!ack, "R3 addr 09h nack", ack, 0);
    send_byte(8'h55, ack);                 chk(!ack, "R3 data ignored", ack, 0);
    bus_stop();
    chk(ctrl_reg == 8'h9C && wp(0) == 7'h22, "R3 no write", ctrl_reg, 'h9C);
  endtask

  task automatic t_pins();
    bit ack;
    bus_start();
    pins = 3'b101;
    send_byte(id_byte(3'b010, 1'b0), ack); chk(ack, "R2 latched pins", ack, 1);
    send_byte(8'h03, ack);
    send_byte(8'h3C, ack);
    bus_start();
    send_byte(id_byte(3'b010, 1'b0), ack); chk(ack, "R2 latched on restart", ack, 1);
    bus_stop();
    chk(wp(3) == 7'h3C, "R2 write done", wp(3), 'h3C);
    bus_start();
    send_byte(id_byte(3'b010, 1'b0), ack); chk(!ack, "R2 old pins nack", ack, 0);
    bus_stop();
    bus_start();
    send_byte(id_byte(3'b101, 1'b0), ack); chk(ack, "R2 new pins ack", ack, 1);
    bus_stop();
    pins = 3'b010;
    hold();
  endtask

  task automatic t_abort();
    bit ack;
    bus_start();
    send_byte(id_byte(3'b010, 1'b0), ack);
    send_byte(8'h01, ack);
    send_bits(8'h5A, 4);
    bus_stop();
    chk(wp(1) == 7'h34, "R8 stop mid byte", wp(1), 'h34);
    bus_start();
    send_byte(id_byte(3'b010, 1'b0), ack);
    send_byte(8'h01, ack);
    send_bits(8'h0F, 5);
    bus_start();
    chk(wp(1) == 7'h34, "R8 start mid byte", wp(1), 'h34);
    send_byte(id_byte(3'b010, 1'b0), ack); chk(ack, "R8 restart id ack", ack, 1);
    send_byte(8'h01, ack);
    send_byte(8'h66, ack);
    bus_stop();
    chk(wp(1) == 7'h66, "R8 recovers", wp(1), 'h66);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_basic();
    t_msb_mask();
    t_wrap();
    t_bad_id();
    t_bad_addr();
    t_pins();
    t_abort();
    chk(r9_viol == 0, "R9 enable moved while clock high", r9_viol, 0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule